// File: doc/BRIEF.md
# MDIO Clause 22 Management Master

This block drives a two-wire PHY management bus on behalf of a host. Software programs a clock divisor and an enable bit, loads the value to send, then issues one control-register write. That write holds the PHY address, the register address, the opcode and an initiate bit, and it starts a complete management frame. Software polls a ready flag to learn when the frame has finished. After a read, the 16-bit value the PHY returned is available from a separate data register.

The management clock is derived from the host clock. Each half-period lasts (div+1) host cycles, so the bus clock runs at f_host / (2·(1+div)). With a 150 MHz host clock, a divisor of 29 keeps the bus clock at or below 2.5 MHz. The data line is driven through an output enable, so a read can hand the line over to the PHY for the turnaround and data bits.

Top module: `mdio_master`

## Requirements
- R1: After reset, the setup word (byte offset 0x500) reads 0, the control word (0x504) reads 0x0000_0080 with only the ready flag set, `mdc` is 0, `mdio_oe` is 0 and `mdio_o` is 1.
- R2: While the enable bit (bit 6 of 0x500) is 1, `mdc` toggles every (div+1) host cycles, where div is bits [5:0] of 0x500. While the enable bit is 0, `mdc` is held at 0 from the next cycle on.
- R3: An initiate request made while the enable bit is 0 is ignored. Ready stays 1 and `mdio_oe` stays 0.
- R4: A write to 0x504 with bit 11 set and a valid opcode starts a frame, using PHY address [28:24], register address [20:16] and opcode [15:14] from that same write. The frame is 64 bits, sent MSB first: 32 ones, then 0 and 1, the opcode, the PHY address, the register address, the turnaround bits 1 and 0, and then 16 data bits. A write frame is driven with `mdio_oe`=1 for all 64 bits. The address and opcode fields read back from 0x504.
- R5: Opcode 2'b10 is a read. The controller drives only the first 46 bits and releases `mdio_oe` for the turnaround and data bits. It samples `mdio_i` on each rising `mdc` edge of the 16 data bits. Once ready returns to 1, the result reads from bits [15:0] of 0x50C.
- R6: Ready (bit 7 of 0x504) reads 0 from the cycle after an accepted initiate. It returns to 1 on the first falling `mdc` edge after the 64th bit.
- R7: An initiate request made while ready is 0 is ignored. The frame in progress completes unchanged.
- R8: An initiate request whose opcode is 2'b00 or 2'b11 is ignored.
- R9: `mdio_o` changes only on a host edge where `mdc` falls.
- R10: Write data is taken from bits [15:0] of 0x508 at the moment a frame is accepted. Writing 0x508 later does not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at `reg_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Management data in |

## Verification
The bench attacks the places where a frame's bit count and bus ownership can go wrong:
- It runs reads and writes at divisors of 0, 2 and 5. An off-by-one in the sequencer shows up as a short or long frame, or as data shifted by one bit.
- The bus model answers only during the data window. A controller that kept driving through the turnaround, or that sampled on the wrong edge, would return a corrupted word.
- Initiate writes are sent while the block is busy, disabled, or carrying an illegal opcode. A design that honoured any of them would restart or corrupt the frame, or drop ready.
- The write-data register is rewritten in mid-frame. A design that read it live, instead of latching it at accept, would leak the new value onto the bus.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DIV_W     = 6;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int PRE_LEN   = 32;
  localparam int HDR_LEN   = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int FRAME_LEN = HDR_LEN + 2 + DATA_W;

  localparam int EN_BIT   = 6;
  localparam int RDY_BIT  = 7;
  localparam int INIT_BIT = 11;
  localparam int OP_LSB   = 14;
  localparam int REG_LSB  = 16;
  localparam int PHY_LSB  = 24;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_WR   = 2'b01,
    OP_RD   = 2'b10,
    OP_BAD  = 2'b11
  } mdio_op_e;

  function automatic logic op_valid(input logic [1:0] op);
    return (op == OP_WR) || (op == OP_RD);
  endfunction

  function automatic logic [FRAME_LEN-1:0] build_frame(
      input logic [1:0] op, input logic [ADDR_W-1:0] phy,
      input logic [ADDR_W-1:0] regad, input logic [DATA_W-1:0] wd);
    return {{PRE_LEN{1'b1}}, 2'b01, op, phy, regad, 2'b10, wd};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic             hit;

  assign hit       = en && (cnt >= div);
  assign rise_tick = hit && !mdc;
  assign fall_tick = hit && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (hit) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2
  mdc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = $clog2(FRAME_LEN + 1);

  logic [FRAME_LEN-1:0] shreg;
  logic [IDX_W-1:0]     idx;
  logic                 rd_mode;
  logic [DATA_W-1:0]    cap;
  logic                 frame_end;
  logic                 in_data;

  assign frame_end = busy && fall_tick && (idx == IDX_W'(FRAME_LEN));
  assign in_data   = idx > IDX_W'(FRAME_LEN - DATA_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      shreg   <= '0;
      idx     <= '0;
      rd_mode <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      cap     <= '0;
      rd_data <= '0;
    end else if (start && !busy) begin
      shreg   <= build_frame(op, phy, regad, wdata);
      rd_mode <= (op == OP_RD);
      idx     <= '0;
      busy    <= 1'b1;
    end else if (busy) begin
      if (frame_end) begin
        busy    <= 1'b0;
        mdio_oe <= 1'b0;
        mdio_o  <= 1'b1;
        if (rd_mode) rd_data <= cap;
      end else if (fall_tick) begin
        mdio_o  <= shreg[FRAME_LEN-1];
        shreg   <= shreg << 1;
        mdio_oe <= !rd_mode || (idx < IDX_W'(HDR_LEN));
        idx     <= idx + 1'b1;
      end
      if (rise_tick && rd_mode && in_data) cap <= {cap[DATA_W-2:0], mdio_i};
    end
  end

  // R9
  mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $past(fall_tick));
  // R5
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_mode && idx > IDX_W'(HDR_LEN)) |-> !mdio_oe);
  // R4
  oe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int         RA_W = 12,
  parameter logic [11:0] BASE = 12'h500
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mdc,
  output logic            mdio_o,
  output logic            mdio_oe,
  input  logic            mdio_i
);
  localparam logic [RA_W-1:0] OFF_SETUP = RA_W'(BASE);
  localparam logic [RA_W-1:0] OFF_CTRL  = RA_W'(BASE + 12'h4);
  localparam logic [RA_W-1:0] OFF_WD    = RA_W'(BASE + 12'h8);
  localparam logic [RA_W-1:0] OFF_RD    = RA_W'(BASE + 12'hC);

  logic              en;
  logic [DIV_W-1:0]  div;
  logic [ADDR_W-1:0] phy_f, reg_f;
  logic [1:0]        op_f;
  logic [DATA_W-1:0] wd_r, rd_data;
  logic              busy, rise_tick, fall_tick;
  logic              sel_setup, sel_ctrl, sel_wd;
  logic              init_req, accept;
  logic [1:0]        req_op;
  logic              unused_wbits;

  assign sel_setup    = reg_wr && (reg_addr == OFF_SETUP);
  assign sel_ctrl     = reg_wr && (reg_addr == OFF_CTRL);
  assign sel_wd       = reg_wr && (reg_addr == OFF_WD);
  assign req_op       = reg_wdata[OP_LSB +: 2];
  assign init_req     = sel_ctrl && reg_wdata[INIT_BIT];
  assign accept       = init_req && en && !busy && op_valid(req_op);
  assign unused_wbits = ^{reg_wdata[31:29], reg_wdata[23:21], reg_wdata[13:12], reg_wdata[10:7]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b0;
      div   <= '0;
      phy_f <= '0;
      reg_f <= '0;
      op_f  <= '0;
      wd_r  <= '0;
    end else begin
      if (sel_setup) begin
        en  <= reg_wdata[EN_BIT];
        div <= reg_wdata[DIV_W-1:0];
      end
      if (sel_ctrl) begin
        phy_f <= reg_wdata[PHY_LSB +: ADDR_W];
        reg_f <= reg_wdata[REG_LSB +: ADDR_W];
        op_f  <= req_op;
      end
      if (sel_wd) wd_r <= reg_wdata[DATA_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_SETUP: begin
        reg_rdata[DIV_W-1:0] = div;
        reg_rdata[EN_BIT]    = en;
      end
      OFF_CTRL: begin
        reg_rdata[PHY_LSB +: ADDR_W] = phy_f;
        reg_rdata[REG_LSB +: ADDR_W] = reg_f;
        reg_rdata[OP_LSB +: 2]       = op_f;
        reg_rdata[RDY_BIT]           = !busy;
      end
      OFF_WD:  reg_rdata[DATA_W-1:0] = wd_r;
      OFF_RD:  reg_rdata[DATA_W-1:0] = rd_data;
      default: reg_rdata = '0;
    endcase
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(en), .div(div),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .op(req_op),
    .phy(reg_wdata[PHY_LSB +: ADDR_W]), .regad(reg_wdata[REG_LSB +: ADDR_W]),
    .wdata(wd_r), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .mdio_i(mdio_i), .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_data(rd_data)
  );

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R3
  disabled_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && !en && !busy) |=> !busy);
  // R8
  bad_op_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && !op_valid(req_op) && !busy) |=> !busy);
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = 12'h504;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  mdio_master dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #4 clk = ~clk;

  int vecs = 0, errs = 0, cyc = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  // Reference for the management clock (R2): half period of div+1 cycles.
  bit m_mdc = 0, m_en = 0;
  int m_cnt = 0, m_div = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mdc = 0; m_en = 0; m_cnt = 0; m_div = 0;
    end else begin
      if (!m_en) begin m_cnt = 0; m_mdc = 0; end
      else if (m_cnt >= m_div) begin m_cnt = 0; m_mdc = !m_mdc; end
      else m_cnt++;
      if (reg_wr && reg_addr == 12'h500) begin
        m_en = reg_wdata[6]; m_div = int'(reg_wdata[5:0]);
      end
    end
  end

  // Bus monitor and PHY model.
  bit cap_on = 0, started = 0, prev_mdc = 0, phy_rd = 0;
  int falls = 0;
  logic [15:0] phy_val = '0;
  bit q_oe[$];
  bit q_o[$];

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 mdc vs model", 32'(mdc), 32'(m_mdc));
      if (cap_on) begin
        if (!started) begin
          if (mdio_oe) begin started = 1; falls = 1; end
        end else begin
          if (prev_mdc && !mdc) begin
            falls++;
            if (phy_rd && falls - 1 >= 48 && falls - 1 <= 63) mdio_i = phy_val[63 - (falls - 1)];
            else mdio_i = 1'b1;
          end
          if (!prev_mdc && mdc && q_oe.size() < 64) begin
            q_oe.push_back(mdio_oe); q_o.push_back(mdio_o);
          end
        end
      end
    end
    prev_mdc = mdc;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      vecs++; errs++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary();
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_word(input logic [1:0] op, input logic [4:0] phy,
                                            input logic [4:0] rg, input bit init);
    logic [31:0] w = '0;
    w[28:24] = phy; w[20:16] = rg; w[15:14] = op; w[11] = init;
    return w;
  endfunction

  function automatic bit exp_bit(input int i, input logic [1:0] op, input logic [4:0] phy,
                                 input logic [4:0] rg, input logic [15:0] wd);
    if (i < 32) return 1;
    if (i == 32) return 0;
    if (i == 33) return 1;
    if (i < 36) return op[35 - i];
    if (i < 41) return phy[40 - i];
    if (i < 46) return rg[45 - i];
    if (i == 46) return 1;
    if (i == 47) return 0;
    return wd[63 - i];
  endfunction

  task automatic start_txn(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input logic [15:0] pv);
    wr(12'h508, {16'h0, wd});
    phy_val = pv; phy_rd = (op == 2'b10);
    q_oe.delete(); q_o.delete(); started = 0; falls = 0;
    wr(12'h504, ctrl_word(op, phy, rg, 1'b1));
    cap_on = 1;
    #1 chk("R6 ready low after accept", 32'(reg_rdata[7]), 32'd0);
  endtask

  task automatic finish_txn(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] wd, input logic [15:0] pv);
    int n = 0;
    reg_addr = 12'h504;
    @(negedge clk);
    while (reg_rdata[7] !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
    cap_on = 0;
    chk("R6 ready returns", 32'(reg_rdata[7]), 32'd1);
    chk("R4 frame length", 32'(q_oe.size()), 32'd64);
    for (int i = 0; i < 64 && i < q_oe.size(); i++) begin
      bit eoe = (op == 2'b01) || (i < 46);
      chk(eoe ? "R4 drive enable" : "R5 bus released", 32'(q_oe[i]), 32'(eoe));
      if (eoe) chk("R4 frame bit", 32'(q_o[i]), 32'(exp_bit(i, op, phy, rg, wd)));
    end
    if (op == 2'b10) begin
      reg_addr = 12'h50C;
      #1 chk("R5 read result", reg_rdata, {16'h0, pv});
      reg_addr = 12'h504;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    reg_addr = 12'h500;
    #1 chk("R1 setup reset", reg_rdata, 32'h0);
    reg_addr = 12'h504;
    #1 chk("R1 ctrl reset", reg_rdata, 32'h0000_0080);
    chk("R1 mdc reset", 32'(mdc), 32'd0);
    chk("R1 oe reset", 32'(mdio_oe), 32'd0);
    chk("R1 mdio_o reset", 32'(mdio_o), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: disabled interface ignores initiate
    wr(12'h500, 32'h03);
    wr(12'h504, ctrl_word(2'b10, 5'h3, 5'h2, 1'b1));
    #1 chk("R3 ready stays high", 32'(reg_rdata[7]), 32'd1);
    repeat (20) @(negedge clk);
    chk("R3 no drive", 32'(mdio_oe), 32'd0);
    chk("R3 ready still high", 32'(reg_rdata[7]), 32'd1);

    // R4: write frame at div 2, then field readback
    wr(12'h500, 32'h42);
    start_txn(2'b01, 5'h13, 5'h0A, 16'hA5C3, 16'h0);
    finish_txn(2'b01, 5'h13, 5'h0A, 16'hA5C3, 16'h0);
    #1 chk("R4 ctrl readback", reg_rdata, 32'h130A_4080);

    // R5: read frame at div 5
    wr(12'h500, 32'h45);
    start_txn(2'b10, 5'h01, 5'h1F, 16'h0, 16'h8E71);
    finish_txn(2'b10, 5'h01, 5'h1F, 16'h0, 16'h8E71);

    // R4/R5 at div 0
    wr(12'h500, 32'h40);
    start_txn(2'b01, 5'h00, 5'h00, 16'hFFFF, 16'h0);
    finish_txn(2'b01, 5'h00, 5'h00, 16'hFFFF, 16'h0);
    start_txn(2'b10, 5'h1F, 5'h11, 16'h0, 16'h0001);
    finish_txn(2'b10, 5'h1F, 5'h11, 16'h0, 16'h0001);

    // R8: illegal opcodes ignored
    wr(12'h500, 32'h41);
    wr(12'h504, ctrl_word(2'b11, 5'h4, 5'h4, 1'b1));
    #1 chk("R8 op 11 ignored", 32'(reg_rdata[7]), 32'd1);
    wr(12'h504, ctrl_word(2'b00, 5'h4, 5'h4, 1'b1));
    #1 chk("R8 op 00 ignored", 32'(reg_rdata[7]), 32'd1);
    repeat (30) @(negedge clk);
    chk("R8 no drive", 32'(mdio_oe), 32'd0);

    // R7: initiate while busy ignored
    start_txn(2'b10, 5'h0C, 5'h05, 16'h0, 16'h3C5A);
    repeat (100) @(negedge clk);
    wr(12'h504, ctrl_word(2'b01, 5'h1A, 5'h1B, 1'b1));
    #1 chk("R7 still busy", 32'(reg_rdata[7]), 32'd0);
    finish_txn(2'b10, 5'h0C, 5'h05, 16'h0, 16'h3C5A);

    // R10: write data latched at accept
    start_txn(2'b01, 5'h07, 5'h09, 16'h1234, 16'h0);
    repeat (50) @(negedge clk);
    wr(12'h508, 32'h0000_DEAD);
    finish_txn(2'b01, 5'h07, 5'h09, 16'h1234, 16'h0);

    // R2: largest practical divisor, then disable
    wr(12'h500, 32'h40 | 32'd29);
    repeat (300) @(negedge clk);
    wr(12'h500, 32'd29);
    repeat (10) @(negedge clk);
    chk("R2 mdc idle when disabled", 32'(mdc), 32'd0);

    summary();
  end
endmodule